// File: doc/BRIEF.md
# Configurable Interrupt Status Controller

This block gathers three raw event conditions, a clock fault and two converter range conditions (over-range and under-range), into one sticky status register and a single active-high interrupt line. Software configures it through a small synchronous register port. Each source has an enable bit and a two-bit trigger code. The trigger code picks whether the source reports the arrival of its condition, the removal of the condition, or the condition while it lasts.

Each condition input is registered once and compared with its previous value to find edges. In the edge modes a detected edge sets a sticky status bit. A read of the status register clears that bit. In level mode the status bit tracks the condition with one cycle of latency. The interrupt output is the OR of the enabled status bits.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the enable, trigger-high, trigger-low and status registers all read 0x00, and `irq_o` is 0.
- R2: The registers decode at these addresses: enable register 0x0E, trigger-high 0x0F, trigger-low 0x10, status 0x0D (read-only). Every register uses the same bit positions: clock fault at bit 3, over-range at bit 1, under-range at bit 0. A write to enable or trigger stores those bits, and a read returns them in the same cycle that `reg_rd` is high.
- R3: Bits 7:4 and bit 2 of every register read as 0 and ignore writes. A read of any other address returns 0x00.
- R4: Trigger code {high bit, low bit} = 00 is rising: a 0-to-1 change of an enabled condition sets its status bit at the next clock edge.
- R5: Trigger code 01 is falling: a 1-to-0 change of an enabled condition sets its status bit.
- R6: Trigger code 10 is level: the status bit equals the condition as sampled on the previous clock edge, and a status read does not clear it.
- R7: Trigger code 11 never sets the status bit.
- R8: An enable bit of 0 keeps its status bit at 0 from the next edge on, so that source cannot raise `irq_o`.
- R9: A read of the status address clears the edge-mode status bits at that clock edge. An edge detected in the same cycle wins, and its bit stays set.
- R10: `irq_o` is high exactly when some status bit is set and its enable bit is 1.
- R11: While `reg_rd` is 0, `reg_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (a status read clears sticky bits) |
| reg_rdata | output | 8 | Read data, valid in the same cycle as `reg_rd` |
| cond_clk_fault | input | 1 | Raw clock-fault condition |
| cond_over_range | input | 1 | Raw over-range condition |
| cond_under_range | input | 1 | Raw under-range condition |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit address and data, and the register addresses listed above. Those values put the reserved bit positions and one unmapped address within reach of the stimulus. The directed part walks every trigger code, the effect of the enable bit, and the case where a read and an edge land in the same cycle. A long random phase then switches trigger codes while conditions toggle, so that a sticky bit held across a mode change gets exercised.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int SRC_N = 3;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_NONE  = 2'b11
  } trig_e;

  // source index -> register bit position (0: under, 1: over, 2: clock fault)
  function automatic int src_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      default: return 3;
    endcase
  endfunction

  // register bit position -> source index (valid only where src_used)
  function automatic int src_idx(input int bitpos);
    case (bitpos)
      1:       return 1;
      3:       return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit src_used(input int bitpos);
    return (bitpos == 0) || (bitpos == 1) || (bitpos == 3);
  endfunction

  function automatic trig_e decode_trig(input logic hi, input logic lo);
    return trig_e'({hi, lo});
  endfunction

  function automatic logic next_status(input trig_e mode, input logic en,
                                       input logic rise, input logic fall,
                                       input logic live, input logic held,
                                       input logic clr);
    if (!en) return 1'b0;
    case (mode)
      TRIG_RISE:  return rise | (held & ~clr);
      TRIG_FALL:  return fall | (held & ~clr);
      TRIG_LEVEL: return live;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SRC_N-1:0]  en_o,
  output logic [SRC_N-1:0]  hi_o,
  output logic [SRC_N-1:0]  lo_o
);

  logic wr_en, wr_hi, wr_lo;
  logic [SRC_N-1:0] wsel;

  assign wr_en = wr_i && (addr_i == EN_ADDR);
  assign wr_hi = wr_i && (addr_i == HI_ADDR);
  assign wr_lo = wr_i && (addr_i == LO_ADDR);

  for (genvar g = 0; g < SRC_N; g++) begin : g_pick
    localparam int P = src_pos(g);
    assign wsel[g] = wdata_i[P];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= '0;
      hi_o <= '0;
      lo_o <= '0;
    end else begin
      if (wr_en) en_o <= wsel;
      if (wr_hi) hi_o <= wsel;
      if (wr_lo) lo_o <= wsel;
    end
  end

  // R2: a write to the enable register lands at the following edge
  assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_o == $past(wsel)));

  // R2: registers hold when no write targets them
  assert_hi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(hi_o));

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic en_i,
  input  logic hi_i,
  input  logic lo_i,
  input  logic clr_i,
  output logic status_o
);

  logic  cond_q;
  logic  rise_evt, fall_evt;
  logic  status_d;
  trig_e mode;

  assign mode     = decode_trig(hi_i, lo_i);
  assign rise_evt = cond_i & ~cond_q;
  assign fall_evt = ~cond_i & cond_q;
  assign status_d = next_status(mode, en_i, rise_evt, fall_evt, cond_i, status_o, clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q   <= 1'b0;
      status_o <= 1'b0;
    end else begin
      cond_q   <= cond_i;
      status_o <= status_d;
    end
  end

  assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode == TRIG_RISE && cond_i && !cond_q) |=> status_o);

  assert_fall_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode == TRIG_FALL && !cond_i && cond_q) |=> status_o);

  assert_level_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode == TRIG_LEVEL) |=> (status_o == $past(cond_i)));

  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_NONE) |=> !status_o);

  assert_disabled_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !status_o);

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clr_i && (mode == TRIG_RISE || mode == TRIG_FALL) && !rise_evt && !fall_evt)
      |=> !status_o);

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ST_ADDR = 8'h0D,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h10
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SRC_N-1:0]  st_i,
  input  logic [SRC_N-1:0]  en_i,
  input  logic [SRC_N-1:0]  hi_i,
  input  logic [SRC_N-1:0]  lo_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] st_x, en_x, hi_x, lo_x;

  for (genvar b = 0; b < DATA_W; b++) begin : g_spread
    localparam bit USED = src_used(b);
    localparam int I    = src_idx(b);
    if (USED) begin : g_live
      assign st_x[b] = st_i[I];
      assign en_x[b] = en_i[I];
      assign hi_x[b] = hi_i[I];
      assign lo_x[b] = lo_i[I];
    end else begin : g_zero
      assign st_x[b] = 1'b0;
      assign en_x[b] = 1'b0;
      assign hi_x[b] = 1'b0;
      assign lo_x[b] = 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if      (addr_i == ST_ADDR) rdata_o = st_x;
      else if (addr_i == EN_ADDR) rdata_o = en_x;
      else if (addr_i == HI_ADDR) rdata_o = hi_x;
      else if (addr_i == LO_ADDR) rdata_o = lo_x;
    end
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ST_ADDR = 8'h0D,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h0F,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cond_clk_fault,
  input  logic              cond_over_range,
  input  logic              cond_under_range,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] RSVD_BITS = ~DATA_W'(8'h0B);

  logic [SRC_N-1:0] cond_v, en_v, hi_v, lo_v, st_v;
  logic             st_clear;

  assign cond_v   = {cond_clk_fault, cond_over_range, cond_under_range};
  assign st_clear = reg_rd && (reg_addr == ST_ADDR);

  irq_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .EN_ADDR(EN_ADDR), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .en_o(en_v), .hi_o(hi_v), .lo_o(lo_v)
  );

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    irq_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .cond_i(cond_v[g]), .en_i(en_v[g]),
      .hi_i(hi_v[g]), .lo_i(lo_v[g]), .clr_i(st_clear), .status_o(st_v[g])
    );
  end

  irq_rd_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ST_ADDR(ST_ADDR),
    .EN_ADDR(EN_ADDR), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
  ) u_rd (
    .rd_i(reg_rd), .addr_i(reg_addr), .st_i(st_v), .en_i(en_v),
    .hi_i(hi_v), .lo_i(lo_v), .rdata_o(reg_rdata)
  );

  assign irq_o = |(st_v & en_v);

  assert_irq_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (st_v != '0));

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSVD_BITS) == '0);

  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));

endmodule

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic [2:0] cond = '0;  // [0] under, [1] over, [2] clock fault
  logic       irq_o;

  always #2.5 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cond_clk_fault(cond[2]), .cond_over_range(cond[1]),
    .cond_under_range(cond[0]), .irq_o(irq_o)
  );

  int checks = 0;
  int fails = 0;
  int pos[3] = '{0, 1, 3};
  int m_en[3], m_hi[3], m_lo[3], m_st[3], m_prev[3];
  logic [7:0] last_rd;
  logic       last_irq;

  task automatic expect_eq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pack(input int v[3]);
    logic [7:0] r = '0;
    for (int i = 0; i < 3; i++) if (v[i] != 0) r[pos[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] model_read(input logic rd, input logic [7:0] a);
    if (!rd) return 8'h00;
    case (a)
      8'h0D: return pack(m_st);
      8'h0E: return pack(m_en);
      8'h0F: return pack(m_hi);
      8'h10: return pack(m_lo);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_irq();
    for (int i = 0; i < 3; i++) if (m_st[i] != 0 && m_en[i] != 0) return 1'b1;
    return 1'b0;
  endfunction

  // one clock: drive at negedge, compare, advance model at posedge
  task automatic step(input logic [7:0] a, input logic wr, input logic [7:0] wd,
                      input logic rd, input logic [2:0] c);
    bit clr;
    reg_addr = a; reg_wr = wr; reg_wdata = wd; reg_rd = rd; cond = c;
    #1;
    last_rd  = reg_rdata;
    last_irq = irq_o;
    expect_eq("R2/R11 read data", reg_rdata, model_read(rd, a));
    expect_eq("R10 irq", {7'd0, irq_o}, {7'd0, model_irq()});
    @(posedge clk);
    clr = rd && (a == 8'h0D);
    for (int i = 0; i < 3; i++) begin
      int cur = int'(c[i]);
      int md  = m_hi[i] * 2 + m_lo[i];
      if (m_en[i] == 0) m_st[i] = 0;
      else if (md == 0 || md == 1) begin
        bit edge_hit = (md == 0) ? (cur == 1 && m_prev[i] == 0) : (cur == 0 && m_prev[i] == 1);
        if (edge_hit) m_st[i] = 1;
        else if (clr) m_st[i] = 0;
      end else if (md == 2) m_st[i] = cur;
      else m_st[i] = 0;
      m_prev[i] = cur;
      if (wr && a == 8'h0E) m_en[i] = int'(wd[pos[i]]);
      if (wr && a == 8'h0F) m_hi[i] = int'(wd[pos[i]]);
      if (wr && a == 8'h10) m_lo[i] = int'(wd[pos[i]]);
    end
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, input logic [2:0] c);
    step(a, 1'b1, d, 1'b0, c);
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [2:0] c);
    step(a, 1'b0, 8'h00, 1'b1, c);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_en[i] = 0; m_hi[i] = 0; m_lo[i] = 0; m_st[i] = 0; m_prev[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd_reg(8'h0E, 3'b000); expect_eq("R1 enable after reset", last_rd, 8'h00);
    rd_reg(8'h0F, 3'b000); expect_eq("R1 trig-high after reset", last_rd, 8'h00);
    rd_reg(8'h10, 3'b000); expect_eq("R1 trig-low after reset", last_rd, 8'h00);
    rd_reg(8'h0D, 3'b000); expect_eq("R1 status after reset", last_rd, 8'h00);
    expect_eq("R1 irq after reset", {7'd0, last_irq}, 8'h00);

    // R2/R3 bit positions and reserved bits
    wr_reg(8'h0E, 8'hFF, 3'b000);
    rd_reg(8'h0E, 3'b000); expect_eq("R2 R3 enable readback", last_rd, 8'h0B);
    wr_reg(8'h0F, 8'hF4, 3'b000);
    rd_reg(8'h0F, 3'b000); expect_eq("R3 reserved-only write", last_rd, 8'h00);
    rd_reg(8'h20, 3'b000); expect_eq("R3 unmapped address", last_rd, 8'h00);

    // R4 rising
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b001);
    rd_reg(8'h0D, 3'b001); expect_eq("R4 rising sets under", last_rd, 8'h01);
    expect_eq("R10 irq high", {7'd0, last_irq}, 8'h01);
    rd_reg(8'h0D, 3'b001); expect_eq("R9 read cleared", last_rd, 8'h00);
    expect_eq("R10 irq low", {7'd0, last_irq}, 8'h00);

    // R5 falling on over-range
    wr_reg(8'h10, 8'h02, 3'b000);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b010);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b010);
    rd_reg(8'h0D, 3'b010); expect_eq("R5 no set while held", last_rd, 8'h00);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b000);
    rd_reg(8'h0D, 3'b000); expect_eq("R5 falling sets over", last_rd, 8'h02);
    rd_reg(8'h0D, 3'b000); expect_eq("R5 cleared by read", last_rd, 8'h00);

    // R6 level on clock fault
    wr_reg(8'h0F, 8'h08, 3'b000);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b100);
    rd_reg(8'h0D, 3'b100); expect_eq("R6 level set", last_rd, 8'h08);
    rd_reg(8'h0D, 3'b100); expect_eq("R6 read keeps level", last_rd, 8'h08);
    rd_reg(8'h0D, 3'b000); expect_eq("R6 one-cycle latency", last_rd, 8'h08);
    rd_reg(8'h0D, 3'b000); expect_eq("R6 follows removal", last_rd, 8'h00);

    // R7 reserved code on under-range
    wr_reg(8'h0F, 8'h01, 3'b000);
    wr_reg(8'h10, 8'h01, 3'b000);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b001);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b000);
    rd_reg(8'h0D, 3'b000); expect_eq("R7 code 11 silent", last_rd, 8'h00);

    // R8 enable gating
    wr_reg(8'h0F, 8'h00, 3'b000);
    wr_reg(8'h10, 8'h00, 3'b000);
    wr_reg(8'h0E, 8'h0B, 3'b000);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b001);
    wr_reg(8'h0E, 8'h0A, 3'b001);
    expect_eq("R10 irq before disable", {7'd0, last_irq}, 8'h01);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b001);
    rd_reg(8'h0D, 3'b001); expect_eq("R8 disabled status cleared", last_rd, 8'h00);
    expect_eq("R8 irq blocked", {7'd0, last_irq}, 8'h00);

    // R9 edge beats read clear
    wr_reg(8'h0E, 8'h0B, 3'b000);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'b000);
    rd_reg(8'h0D, 3'b010); expect_eq("R9 status before edge", last_rd, 8'h00);
    rd_reg(8'h0D, 3'b010); expect_eq("R9 edge wins over clear", last_rd, 8'h02);

    // R11 idle read data
    step(8'h0E, 1'b0, 8'h00, 1'b0, 3'b010);
    expect_eq("R11 rdata idle", last_rd, 8'h00);

    // random phase, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a, d;
      logic wr, rd;
      logic [2:0] c;
      int sel = $urandom_range(0, 5);
      a  = (sel == 0) ? 8'h0D : (sel == 1) ? 8'h0E : (sel == 2) ? 8'h0F :
           (sel == 3) ? 8'h10 : (sel == 4) ? 8'h0D : 8'($urandom);
      wr = ($urandom_range(0, 3) == 0);
      rd = !wr && ($urandom_range(0, 1) == 0);
      d  = 8'($urandom);
      c  = cond ^ 3'($urandom_range(0, 7) & $urandom_range(0, 7));
      step(a, wr, d, rd, c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule